// File: doc/BRIEF.md
# Display Bus Reading to Serial Text Line

This block listens to the parallel bus that feeds a five-digit numeric display. The bus carries packed decimal digits and four status lines. The block waits for a display update to finish, which it sees as the active-low blanking line returning high. It then waits for the whole word to settle and captures the reading as one coherent value. A formatter turns the reading into a fixed-width printable text line. A transmit-only asynchronous serial port sends that line over and over on one wire, with no handshake of any kind.

The text line is always nine characters long, so a listener can locate the fields by column. While the display is blanked, or before any reading has been captured, the block sends a dash marker in place of the digits.

Top module: `bcd_disp_uart`

## Requirements
- R1: While `rst` is high, `ser_tx_o` is high. Until the first reading is captured, every line sent is the invalid marker of R6.
- R2: Every character goes out as one start bit (0), eight data bits with the LSB first, and one stop bit (1). Each bit lasts `CLKS_PER_BIT` clock cycles, and the line idles high.
- R3: A line is nine characters, in this order: the sign column ('+' when bus bit 21 is 1, otherwise space), the one column ('1' when bus bit 20 is 1, otherwise space), five digit characters (from bus bits 19:16 first down to bits 3:0 last), then CR (0x0D) and LF (0x0A).
- R4: A digit nibble of 0 to 9 is printed as '0' plus its value. A nibble of 10 to 15 is printed as '?'.
- R5: Zero suppression applies when bus bit 22 is 1 and bit 20 is 0. Each zero nibble that comes before the first non-zero nibble, with '?' nibbles counting as non-zero, is printed as a space. The last digit is always printed.
- R6: Bus bit 23 is the blanking line, and it is active low. A line whose first character starts while the synchronized blanking line is low is sent as two spaces, five '-' characters, CR and LF.
- R7: A reading is captured only if the blanking line has been low at some point since the previous capture, or since reset. A change of the bus while blanking stays high does not change the lines sent.
- R8: After the two-flop synchronizer, the bus must hold the same value for `STABLE_CNT` consecutive cycles before a capture. A word held for a shorter time is never captured.
- R9: Lines are sent back to back without end. The content of each line is fixed when its first character is sent, and the same reading produces identical lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| disp_bus_i | input | 24 | Display bus: digit nibbles in bits 19:0, one flag in bit 20, sign flag in bit 21, zero-suppress flag in bit 22, blanking (active low) in bit 23 |
| ser_tx_o | output | 1 | Asynchronous serial transmit line, idle high |

## Verification
A wrong capture state, such as a missing arm flag or a weak settle filter, shows up as a stale or glitched reading in the second full line after the stimulus. Checking that line gives a bound of about two line times. Errors in formatting or zero suppression show up in particular columns of that same line. A broken bit counter or divider damages the very next frame, and the software receiver in the bench counts that as a framing error or a wrong character.

// File: rtl/bdu_pkg.sv
package bdu_pkg;
    localparam int NDIG     = 5;
    localparam int LINE_LEN = NDIG + 4;
    localparam int IDX_W    = $clog2(LINE_LEN);

    typedef logic [7:0] char_t;

    typedef struct packed {
        logic                 blank_n;
        logic                 zsup;
        logic                 plus;
        logic                 one;
        logic [NDIG-1:0][3:0] dig;
    } disp_word_t;

    localparam int BUS_W = $bits(disp_word_t);

    typedef logic [LINE_LEN-1:0][7:0] line_t;

    localparam char_t CH_CR   = 8'h0D;
    localparam char_t CH_LF   = 8'h0A;
    localparam char_t CH_SP   = 8'h20;
    localparam char_t CH_DASH = 8'h2D;
    localparam char_t CH_PLUS = 8'h2B;
    localparam char_t CH_ONE  = 8'h31;
    localparam char_t CH_ZERO = 8'h30;
    localparam char_t CH_BAD  = 8'h3F;
endpackage

// File: rtl/bdu_capture.sv
module bdu_capture
    import bdu_pkg::*;
#(
    parameter int STABLE_CNT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] bus_i,
    output disp_word_t       live_o,
    output disp_word_t       rd_o,
    output logic             have_o,
    output logic             cap_o
);
    localparam int CNT_W = $clog2(STABLE_CNT + 1);

    typedef struct packed {
        disp_word_t       s1;
        disp_word_t       s2;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        disp_word_t       rd;
        logic             have;
    } cap_st_t;

    localparam cap_st_t CAP_RST = '{s1: '0, s2: '0, cnt: '0, armed: 1'b1, rd: '0, have: 1'b0};

    cap_st_t cap_d, cap_q;
    logic    take;

    always_comb begin
        cap_d    = cap_q;
        cap_d.s1 = bus_i;
        cap_d.s2 = cap_q.s1;
        if (cap_q.s1 == cap_q.s2) begin
            if (cap_q.cnt != CNT_W'(STABLE_CNT)) begin
                cap_d.cnt = cap_q.cnt + 1'b1;
            end
        end else begin
            cap_d.cnt = '0;
        end
        take = cap_q.armed && cap_q.s2.blank_n && (cap_q.cnt == CNT_W'(STABLE_CNT));
        if (!cap_q.s2.blank_n) begin
            cap_d.armed = 1'b1;
        end
        if (take) begin
            cap_d.rd    = cap_q.s2;
            cap_d.have  = 1'b1;
            cap_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= CAP_RST;
        else     cap_q <= cap_d;
    end

    assign live_o = cap_q.s2;
    assign rd_o   = cap_q.rd;
    assign have_o = cap_q.have;
    assign cap_o  = take;
endmodule

// File: rtl/bdu_format.sv
module bdu_format
    import bdu_pkg::*;
(
    input  disp_word_t word_i,
    input  logic       ok_i,
    output line_t      line_o
);
    logic [NDIG:0]        lead;
    logic [NDIG-1:0][7:0] dch;

    assign lead[NDIG] = word_i.zsup && !word_i.one;

    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        logic is_zero;
        assign is_zero = (word_i.dig[k] == 4'd0);
        assign lead[k] = lead[k+1] && is_zero;
        assign dch[k]  = (k != 0 && lead[k])       ? CH_SP  :
                         (word_i.dig[k] > 4'd9)     ? CH_BAD :
                         CH_ZERO + {4'd0, word_i.dig[k]};
    end

    always_comb begin
        line_o[0] = (ok_i && word_i.plus) ? CH_PLUS : CH_SP;
        line_o[1] = (ok_i && word_i.one)  ? CH_ONE  : CH_SP;
        for (int i = 0; i < NDIG; i++) begin
            line_o[2+i] = ok_i ? dch[NDIG-1-i] : CH_DASH;
        end
        line_o[LINE_LEN-2] = CH_CR;
        line_o[LINE_LEN-1] = CH_LF;
    end
endmodule

// File: rtl/bdu_uart_tx.sv
module bdu_uart_tx #(
    parameter int CLKS_PER_BIT = 6667
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       busy_o,
    output logic       tx_o
);
    localparam int DIV_W      = $clog2(CLKS_PER_BIT);
    localparam int FRAME_BITS = 10;

    typedef struct packed {
        logic             busy;
        logic             tx;
        logic [8:0]       sh;
        logic [3:0]       nbit;
        logic [DIV_W-1:0] div;
    } utx_st_t;

    localparam utx_st_t UTX_RST = '{busy: 1'b0, tx: 1'b1, sh: '0, nbit: '0, div: '0};

    utx_st_t utx_d, utx_q;

    always_comb begin
        utx_d = utx_q;
        if (!utx_q.busy) begin
            if (start_i) begin
                utx_d.busy = 1'b1;
                utx_d.tx   = 1'b0;
                utx_d.sh   = {1'b1, data_i};
                utx_d.nbit = '0;
                utx_d.div  = '0;
            end
        end else if (utx_q.div == DIV_W'(CLKS_PER_BIT - 1)) begin
            utx_d.div = '0;
            if (utx_q.nbit == 4'(FRAME_BITS - 1)) begin
                utx_d.busy = 1'b0;
                utx_d.tx   = 1'b1;
            end else begin
                utx_d.tx   = utx_q.sh[0];
                utx_d.sh   = {1'b1, utx_q.sh[8:1]};
                utx_d.nbit = utx_q.nbit + 1'b1;
            end
        end else begin
            utx_d.div = utx_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) utx_q <= UTX_RST;
        else     utx_q <= utx_d;
    end

    assign busy_o = utx_q.busy;
    assign tx_o   = utx_q.tx;
endmodule

// File: rtl/bcd_disp_uart.sv
module bcd_disp_uart
    import bdu_pkg::*;
#(
    parameter int CLKS_PER_BIT = 6667,
    parameter int STABLE_CNT   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] disp_bus_i,
    output logic             ser_tx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        line_t            line;
    } seq_st_t;

    seq_st_t    seq_d, seq_q;
    disp_word_t live_word, cap_word;
    logic       have, cap_stb, tx_busy, tx_start;
    char_t      tx_byte;
    line_t      fmt_line;
    logic [IDX_W-1:0] idx_w;
    line_t      line_w;

    bdu_capture #(.STABLE_CNT(STABLE_CNT)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .bus_i  (disp_bus_i),
        .live_o (live_word),
        .rd_o   (cap_word),
        .have_o (have),
        .cap_o  (cap_stb)
    );

    bdu_format u_fmt (
        .word_i (cap_word),
        .ok_i   (have && live_word.blank_n),
        .line_o (fmt_line)
    );

    bdu_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (tx_start),
        .data_i  (tx_byte),
        .busy_o  (tx_busy),
        .tx_o    (ser_tx_o)
    );

    always_comb begin
        seq_d    = seq_q;
        tx_start = !tx_busy;
        tx_byte  = (seq_q.idx == '0) ? fmt_line[0] : seq_q.line[seq_q.idx];
        if (tx_start) begin
            if (seq_q.idx == '0) begin
                seq_d.line = fmt_line;
            end
            seq_d.idx = (seq_q.idx == IDX_W'(LINE_LEN - 1)) ? '0 : seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assign idx_w  = seq_q.idx;
    assign line_w = seq_q.line;
endmodule

// File: rtl/bdu_checker.sv
module bdu_checker
    import bdu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx,
    input logic             busy,
    input logic             cap,
    input disp_word_t       live,
    input disp_word_t       rd,
    input logic [IDX_W-1:0] idx,
    input line_t            line
);
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx);

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
        idx < IDX_W'(LINE_LEN));

    assert_latch_R7: assert property (@(posedge clk) disable iff (rst)
        cap |=> (rd == $past(live)));

    assert_settled_R8: assert property (@(posedge clk) disable iff (rst)
        cap |-> (live == $past(live)));

    assert_line_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (idx != '0 && $past(idx) != '0) |-> $stable(line));
endmodule

bind bcd_disp_uart bdu_checker chk_i (
    .clk  (clk),
    .rst  (rst),
    .tx   (ser_tx_o),
    .busy (tx_busy),
    .cap  (cap_stb),
    .live (live_word),
    .rd   (cap_word),
    .idx  (idx_w),
    .line (line_w)
);

// File: tb/bcd_disp_uart_tb_top.sv
module bcd_disp_uart_tb_top;
    localparam int CPB = 16;
    localparam int STB = 4;
    localparam int NV  = 9;

    // stimulus word, expected seven visible characters (R3 R4 R5)
    localparam logic [79:0] VEC [NV] = '{
        {24'h812345, "  12345"},   // R3 plain
        {24'hA00042, "+ 00042"},   // R3 sign, no suppression
        {24'hC00042, "     42"},   // R5 suppression
        {24'hD00042, " 100042"},   // R5 one column blocks suppression
        {24'hC00000, "      0"},   // R5 last digit kept
        {24'h80AB05, "  0??05"},   // R4 bad nibbles
        {24'hC0AB05, "   ??05"},   // R4 R5 bad nibble ends suppression
        {24'hF99999, "+199999"},   // R3 all flags
        {24'hE00701, "+   701"}    // R5 with sign
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus = '0;
    logic        ser_tx;

    int          total = 0;
    int          bad = 0;
    int          nlines = 0;
    int          ferr = 0;
    bit          done = 1'b0;
    logic [71:0] win = '0;
    logic [71:0] last_line = '0;

    always #4 clk = ~clk;

    bcd_disp_uart #(.CLKS_PER_BIT(CPB), .STABLE_CNT(STB)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .disp_bus_i (bus),
        .ser_tx_o   (ser_tx)
    );

    // software receiver, 8N1, mid-bit sampling
    initial begin
        logic [7:0] ch;
        #1;
        wait (rst == 1'b0);
        forever begin
            @(negedge ser_tx);
            repeat (CPB / 2) @(posedge clk);
            #1;
            if (ser_tx !== 1'b0) ferr++;
            for (int b = 0; b < 8; b++) begin
                repeat (CPB) @(posedge clk);
                #1;
                ch[b] = ser_tx;
            end
            repeat (CPB) @(posedge clk);
            #1;
            if (ser_tx !== 1'b1) ferr++;
            win = {win[63:0], ch};
            if (ch == 8'h0A) begin
                last_line = win;
                nlines++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_line(input logic [55:0] e, input string req);
        chk(last_line === {e, 16'h0D0A}, req, "line", last_line, {e, 16'h0D0A});
    endtask

    task automatic wait_lines(input int k);
        int n0 = nlines;
        while (nlines < n0 + k) @(posedge clk);
    endtask

    task automatic apply(input logic [23:0] v);
        @(negedge clk) bus = v & 24'h7FFFFF;
        repeat (10) @(negedge clk);
        bus = v;
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", nlines, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [71:0] held;
        repeat (5) @(negedge clk);
        chk(ser_tx === 1'b1, "R1", "tx during reset", {71'd0, ser_tx}, 72'd1);
        rst = 1'b0;

        // R1 R6: no capture yet and blanking low -> marker
        wait_lines(2);
        check_line("  -----", "R1");

        // R9: repetition with identical content
        held = last_line;
        wait_lines(1);
        chk(last_line === held, "R9", "repeat", last_line, held);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][79:56]);
            wait_lines(2);
            check_line(VEC[i][55:0], "R3 R4 R5");
        end

        // R7: change without blanking is ignored
        @(negedge clk) bus = 24'h812345;
        repeat (30) @(negedge clk);
        wait_lines(2);
        check_line("+   701", "R7");

        // R6: live blanking low -> marker, then capture after it rises
        @(negedge clk) bus = 24'h012345;
        repeat (30) @(negedge clk);
        wait_lines(2);
        check_line("  -----", "R6");
        @(negedge clk) bus = 24'h812345;
        repeat (30) @(negedge clk);
        wait_lines(2);
        check_line("  12345", "R7");

        // R8: a two-cycle word is not captured
        @(negedge clk) bus = 24'h000000;
        repeat (10) @(negedge clk);
        bus = 24'h800777;
        repeat (2) @(negedge clk);
        bus = 24'h800555;
        repeat (30) @(negedge clk);
        wait_lines(2);
        check_line("  00555", "R8");

        // R2: framing across the whole run
        chk(ferr == 0 && nlines > 10, "R2", "framing errors", 72'(ferr), 72'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule